// File: doc/BRIEF.md
# Three-Bank Level Interrupt Aggregator

This block collects level-sensitive interrupt lines from three groups and reduces them to a single interrupt request for the processor. Group 0 has 8 lines. Groups 1 and 2 have 32 lines each. Each group keeps an enable mask. The mask is changed through a set port and a clear port on a small 32-bit register bus, and both ports read back the current mask. A group's pending word is the AND of its live source lines and its mask.

The group 0 pending word is also the top-level status word. It carries the 8 group 0 lines, one summary flag for each wide group, and a fixed set of direct-copy bits for selected lines of groups 1 and 2. A selected line shows only in its direct-copy bit and in its own group's word. It does not raise the summary flag. This lets a handler find the most common sources with one read. The summary and direct-copy bits have no mask in group 0. They are gated only by the owning group's mask.

Top module: `banked_irq_aggregator`

## Requirements
- R1: While reset is active, and after it is released, every mask is zero, every register reads zero, and `irq_out` is low, even with all sources high. Mask writes made while reset is applied have no effect.
- R2: A write to a set port makes every mask bit whose write bit is 1 equal to 1 and leaves the others unchanged; reading a set port returns the mask. Set ports: 0x10 group 1, 0x14 group 2, 0x18 group 0.
- R3: A write to a clear port makes every mask bit whose write bit is 1 equal to 0 and leaves the others unchanged; reading a clear port returns the mask. Clear ports: 0x1C group 1, 0x20 group 2, 0x24 group 0.
- R4: Reading 0x04 (group 1) or 0x08 (group 2) returns the source lines ANDed with that group's mask, following the source levels in the same cycle.
- R5: Reading 0x00 returns, in bits 7:0, the group 0 source lines ANDed with the group 0 mask.
- R6: Bit 8 of the word at 0x00 is 1 exactly when some enabled, pending group 1 line outside the direct-copy set is high. Bit 9 does the same for group 2.
- R7: Group 1 lines 7, 9, 10, 18, 19 appear, in that order, at bits 10 to 14 of the word at 0x00. Group 2 lines 21, 22, 23, 24, 25, 30 appear, in that order, at bits 15 to 20. Each copy equals the line's bit in its own group's pending word.
- R8: Bits 8 to 31 of writes to 0x18 and 0x24 have no effect. The group 0 mask reads back with bits 31:8 at zero, and the group 1 and group 2 masks do not change.
- R9: Bits 31:21 of the word at 0x00 read zero. `irq_out` is 1 exactly when that word is nonzero.
- R10: Every address other than the nine listed above reads zero, and `bus_rdata` is zero when `bus_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_g0 | input | 8 | Group 0 level source lines |
| src_g1 | input | 32 | Group 1 level source lines |
| src_g2 | input | 32 | Group 2 level source lines |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The hardest case to set up is a group in which a direct-copy line and an ordinary line are enabled and pending together. The summary flag must then follow only the ordinary line, while group 0 writes aimed at the direct-copy positions try to mask them. Directed steps enable both kinds of line, then drop them one at a time. They then flood the group 0 set and clear ports with all-ones. A long random phase follows, with sparse source patterns and mixed set and clear writes. It is compared every cycle against a behavioural model that walks the direct-copy lists itself.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int G0_SRCS  = 8;
  localparam int GRP_W    = 32;
  localparam int ADDR_W   = 6;
  localparam int N_DC1    = 5;
  localparam int N_DC2    = 6;
  localparam int SUM1_BIT = 8;
  localparam int SUM2_BIT = 9;
  localparam int DC1_BASE = 10;
  localparam int DC2_BASE = DC1_BASE + N_DC1;
  localparam int TOP_USED = DC2_BASE + N_DC2;

  localparam int DC1_SRC [N_DC1] = '{7, 9, 10, 18, 19};
  localparam int DC2_SRC [N_DC2] = '{21, 22, 23, 24, 25, 30};

  localparam logic [ADDR_W-1:0] A_PEND0 = 6'h00;
  localparam logic [ADDR_W-1:0] A_PEND1 = 6'h04;
  localparam logic [ADDR_W-1:0] A_PEND2 = 6'h08;
  localparam logic [ADDR_W-1:0] A_SET1  = 6'h10;
  localparam logic [ADDR_W-1:0] A_SET2  = 6'h14;
  localparam logic [ADDR_W-1:0] A_SET0  = 6'h18;
  localparam logic [ADDR_W-1:0] A_CLR1  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CLR2  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CLR0  = 6'h24;

  function automatic logic [GRP_W-1:0] dc1_mask();
    logic [GRP_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_DC1; i++) m[DC1_SRC[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_W-1:0] dc2_mask();
    logic [GRP_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_DC2; i++) m[DC2_SRC[i]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         upd;

  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d = mask_d | wbits;
    if (clr_we) mask_d = mask_d & ~wbits;
  end

  assign upd = set_we | clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (upd) mask_q <= mask_d;
  end

  assign mask = mask_q;

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((mask & $past(wbits)) == $past(wbits)));

  assert_clear_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((mask & $past(wbits)) == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(mask));
endmodule

// File: rtl/irq_top_word.sv
module irq_top_word
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [G0_SRCS-1:0] pend_g0,
  input  logic [GRP_W-1:0]   pend_g1,
  input  logic [GRP_W-1:0]   pend_g2,
  output logic [GRP_W-1:0]   word
);
  localparam logic [GRP_W-1:0] DC1_M = dc1_mask();
  localparam logic [GRP_W-1:0] DC2_M = dc2_mask();

  logic [N_DC1-1:0] dc1_bits;
  logic [N_DC2-1:0] dc2_bits;

  for (genvar i = 0; i < N_DC1; i++) begin : g_dc1
    assign dc1_bits[i] = pend_g1[DC1_SRC[i]];
    assert_dc1_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word[DC1_BASE+i] |-> pend_g1[DC1_SRC[i]]);
  end

  for (genvar i = 0; i < N_DC2; i++) begin : g_dc2
    assign dc2_bits[i] = pend_g2[DC2_SRC[i]];
    assert_dc2_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word[DC2_BASE+i] |-> pend_g2[DC2_SRC[i]]);
  end

  always_comb begin
    word = '0;
    word[G0_SRCS-1:0]               = pend_g0;
    word[SUM1_BIT]                  = |(pend_g1 & ~DC1_M);
    word[SUM2_BIT]                  = |(pend_g2 & ~DC2_M);
    word[DC1_BASE +: N_DC1]         = dc1_bits;
    word[DC2_BASE +: N_DC2]         = dc2_bits;
  end
endmodule

// File: rtl/banked_irq_aggregator.sv
module banked_irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        src_g0,
  input  logic [31:0]       src_g1,
  input  logic [31:0]       src_g2,
  output logic              irq_out
);
  logic rst_sync_n;
  logic wr_ok;
  logic set0, set1, set2, clr0, clr1, clr2;
  logic [G0_SRCS-1:0] mask_g0;
  logic [GRP_W-1:0]   mask_g1, mask_g2;
  logic [G0_SRCS-1:0] pend_g0;
  logic [GRP_W-1:0]   pend_g1, pend_g2;
  logic [GRP_W-1:0]   top_word;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_ok = bus_en & bus_wr;
  assign set0  = wr_ok & (bus_addr == A_SET0);
  assign set1  = wr_ok & (bus_addr == A_SET1);
  assign set2  = wr_ok & (bus_addr == A_SET2);
  assign clr0  = wr_ok & (bus_addr == A_CLR0);
  assign clr1  = wr_ok & (bus_addr == A_CLR1);
  assign clr2  = wr_ok & (bus_addr == A_CLR2);

  irq_mask_bank #(.W(G0_SRCS)) u_mask_g0 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (set0),
    .clr_we (clr0),
    .wbits  (bus_wdata[G0_SRCS-1:0]),
    .mask   (mask_g0)
  );

  irq_mask_bank #(.W(GRP_W)) u_mask_g1 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (set1),
    .clr_we (clr1),
    .wbits  (bus_wdata),
    .mask   (mask_g1)
  );

  irq_mask_bank #(.W(GRP_W)) u_mask_g2 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (set2),
    .clr_we (clr2),
    .wbits  (bus_wdata),
    .mask   (mask_g2)
  );

  assign pend_g0 = src_g0 & mask_g0;
  assign pend_g1 = src_g1 & mask_g1;
  assign pend_g2 = src_g2 & mask_g2;

  irq_top_word u_word (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pend_g0 (pend_g0),
    .pend_g1 (pend_g1),
    .pend_g2 (pend_g2),
    .word    (top_word)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      unique case (bus_addr)
        A_PEND0:        bus_rdata = top_word;
        A_PEND1:        bus_rdata = pend_g1;
        A_PEND2:        bus_rdata = pend_g2;
        A_SET0, A_CLR0: bus_rdata = {{(GRP_W-G0_SRCS){1'b0}}, mask_g0};
        A_SET1, A_CLR1: bus_rdata = mask_g1;
        A_SET2, A_CLR2: bus_rdata = mask_g2;
        default:        bus_rdata = '0;
      endcase
    end
  end

  assign irq_out = |top_word;

  assert_g0_port_isolated_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set0 || clr0) |=> ($stable(mask_g1) && $stable(mask_g2)));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_en && bus_addr == A_PEND0) |-> (bus_rdata[GRP_W-1:TOP_USED] == '0));

  assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((mask_g0 == '0) && (mask_g1 == '0) && (mask_g2 == '0)) |-> !irq_out);
endmodule

// File: tb/banked_irq_aggregator_bench.sv
module banked_irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_g0 = '0;
  logic [31:0] src_g1 = '0;
  logic [31:0] src_g2 = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  bit finished = 1'b0;

  logic [7:0]  m0 = '0;
  logic [31:0] m1 = '0;
  logic [31:0] m2 = '0;

  int list1 [5] = '{7, 9, 10, 18, 19};
  int list2 [6] = '{21, 22, 23, 24, 25, 30};
  logic [5:0] addr_pool [11] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14,
                                 6'h18, 6'h1C, 6'h20, 6'h24, 6'h28};

  always #2 clk = ~clk;

  banked_irq_aggregator u_banked_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_g0(src_g0), .src_g1(src_g1), .src_g2(src_g2), .irq_out(irq_out)
  );

  function automatic logic [31:0] model_top();
    logic [31:0] w;
    logic [31:0] q1;
    logic [31:0] q2;
    bit hit;
    w  = {24'b0, src_g0 & m0};
    q1 = src_g1 & m1;
    q2 = src_g2 & m2;
    for (int j = 0; j < 32; j++) begin
      hit = 0;
      foreach (list1[k]) if (list1[k] == j) hit = 1;
      if (q1[j] && !hit) w[8] = 1'b1;
      hit = 0;
      foreach (list2[k]) if (list2[k] == j) hit = 1;
      if (q2[j] && !hit) w[9] = 1'b1;
    end
    foreach (list1[k]) w[10+k] = q1[list1[k]];
    foreach (list2[k]) w[15+k] = q2[list2[k]];
    return w;
  endfunction

  function automatic logic [31:0] model_read(input logic en, input logic [5:0] a);
    if (!en) return 32'h0;
    case (a)
      6'h00: return model_top();
      6'h04: return src_g1 & m1;
      6'h08: return src_g2 & m2;
      6'h18, 6'h24: return {24'b0, m0};
      6'h10, 6'h1C: return m1;
      6'h14, 6'h20: return m2;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input logic en, input logic [5:0] a);
    if (!en) return "R10";
    case (a)
      6'h00: return "R5 R6 R7";
      6'h04, 6'h08: return "R4";
      6'h10, 6'h14, 6'h18: return "R2";
      6'h1C, 6'h20, 6'h24: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic wr, input logic [5:0] a,
                     input logic [31:0] wd, input string tag);
    bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    if (live && en && wr) begin
      case (a)
        6'h18: m0 = m0 | wd[7:0];
        6'h24: m0 = m0 & ~wd[7:0];
        6'h10: m1 = m1 | wd;
        6'h1C: m1 = m1 & ~wd;
        6'h14: m2 = m2 | wd;
        6'h20: m2 = m2 & ~wd;
        default: ;
      endcase
    end
    @(negedge clk);
    chk((tag == "") ? tag_for(en, a) : tag, bus_rdata, model_read(en, a));
    chk("R9", {31'b0, irq_out}, {31'b0, (model_top() != 0)});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    src_g0 = 8'hFF; src_g1 = '1; src_g2 = '1;
    @(negedge clk);
    // R1: writes under reset ignored, everything reads zero
    cyc(1, 1, 6'h18, '1, "R1");
    cyc(1, 1, 6'h10, '1, "R1");
    foreach (addr_pool[i]) cyc(1, 0, addr_pool[i], '0, "R1");
    rst_n = 1'b1;
    repeat (3) cyc(1, 0, 6'h00, '0, "R1");
    cyc(1, 0, 6'h10, '0, "R1");
    live = 1'b1;

    // R6 R7: direct-copy line and ordinary line together
    src_g0 = '0; src_g1 = 32'h0000_0088; src_g2 = '0;
    cyc(1, 1, 6'h10, 32'h0000_0088, "R2");
    cyc(1, 0, 6'h00, '0, "R6");
    src_g1 = 32'h0000_0080;
    cyc(1, 0, 6'h00, '0, "R7");
    src_g1 = 32'h0000_0008;
    cyc(1, 0, 6'h00, '0, "R6");
    src_g2 = 32'h4000_0001;
    cyc(1, 1, 6'h14, 32'h4000_0001, "R2");
    cyc(1, 0, 6'h00, '0, "R7");
    src_g2 = 32'h4000_0000;
    cyc(1, 0, 6'h00, '0, "R7");
    src_g1 = 32'h0000_0080;
    // R3: clear one line
    cyc(1, 1, 6'h1C, 32'h0000_0080, "R3");
    cyc(1, 0, 6'h00, '0, "R3");
    // R2: zero write leaves mask
    cyc(1, 1, 6'h10, 32'h0, "R2");
    cyc(1, 0, 6'h10, '0, "R2");
    // R8: group 0 ports cannot touch upper or other groups
    cyc(1, 1, 6'h18, '1, "R8");
    cyc(1, 0, 6'h18, '0, "R8");
    cyc(1, 1, 6'h24, 32'hFFFF_FF00, "R8");
    cyc(1, 0, 6'h10, '0, "R8");
    cyc(1, 0, 6'h14, '0, "R8");
    src_g0 = 8'h21;
    cyc(1, 0, 6'h00, '0, "R5");
    cyc(1, 1, 6'h24, 32'h0000_0001, "R3");
    cyc(1, 0, 6'h00, '0, "R5");
    // R10: unmapped and idle reads
    cyc(1, 0, 6'h0C, '0, "R10");
    cyc(1, 0, 6'h3C, '0, "R10");
    cyc(0, 0, 6'h00, '0, "R10");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] wd;
      if ($urandom_range(0, 3) == 0) begin
        src_g0 = 8'($urandom);
        src_g1 = $urandom & $urandom;
        src_g2 = $urandom & $urandom;
      end
      wd = ($urandom_range(0, 1) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      cyc($urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0,
          addr_pool[$urandom_range(0, 10)], wd, "");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule